// File: doc/BRIEF.md
# Dual Programmable Interval Timer

This block holds two 16-bit down-counting timers behind a byte-wide register interface. Software writes a reload value into each timer's 16-bit latch one byte at a time. Writing the high byte loads the whole latch into the counter and starts a fresh count. Each counter decrements once per clock. When a counter passes through zero, the timer raises its interrupt flag.

Timer 1 runs in one of two modes. In one-shot mode it gives one interrupt per load. In free-running mode it reloads from its latch after each expiry and interrupts periodically. Timer 2 supports only the one-shot mode, and a control bit can silence its interrupts altogether. An interrupt flag register and an interrupt enable register combine into one active-high interrupt line. Flags are cleared by writing a 1 to them, by reading the timer's low counter byte, or by reloading the timer.

Top module: `dit_top`

## Requirements
- R1: After reset, all of the following read back as 0 and `irq` stays low: counters, latches, control, flags and enables. No flag is raised until a timer has been loaded with a high-byte write.
- R2: Register addresses are as follows. Timer 1 uses address 0 (counter low), 1 (counter high), 2 (latch low) and 3 (latch high). Timer 2 uses addresses 4 to 7 in the same arrangement. A write to a counter-low address changes only the low half of the latch and leaves the counter running. A write to a counter-high address sets the high half of the latch and, on the same edge, loads the counter with the full 16-bit latch.
- R3: The counter is readable at its counter-low and counter-high addresses. If it is loaded with N, it reads N-k after k further clocks, and it wraps from 0x0000 to 0xFFFF.
- R4: In one-shot mode, the flag is set N+1 clocks after the edge that loaded N. Only one flag is raised per load, even after the counter wraps and passes zero again.
- R5: Control register (address 8) bit 6 set to 1 puts timer 1 in free-running mode. The counter reloads from the latch on the clock after it reaches 0xFFFF, and the flag is set again every N+2 clocks.
- R6: Control register bit 5 set to 1 prevents timer 2 from ever setting its flag. Its counter still decrements.
- R7: Flag clearing works in three ways. Writing a 1 to a bit of the flag register (address 9) clears that flag, while a 0 bit has no effect. A read (`rd_en`) of a timer's counter-low address clears that timer's flag, while a read of the counter-high address does not. A write to a timer's counter-high address clears that timer's flag.
- R8: In the flag register (address 9) and the enable register (address 10), bit 6 belongs to timer 1 and bit 5 to timer 2. `irq` is high exactly when some flag and its matching enable bit are both set. Flag register bit 7 reads back as `irq`.
- R9: A control write takes effect at once. If timer 1 is switched from free-running to one-shot after an expiry, it raises no further flag until it is loaded again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe (for clear-on-read) |
| rd_data | output | 8 | Read data, combinational from `addr` |
| irq | output | 1 | Combined interrupt, active high |

## Verification
The hardest situation to reach from the ports is a one-shot timer whose counter has already wrapped through zero once after firing. Proving that no second flag appears needs a full 65,536-clock revolution with the flag cleared beforehand. The bench reaches it by loading a small value, clearing the flag when it fires, and then watching `irq` over more than one full wrap.

A second hard case is the mode switch. The bench switches timer 1 from free-running to one-shot in the cycle right after an expiry, while its reload is still pending. It then checks that the reloaded count expires silently.

// File: rtl/dit_pkg.sv
package dit_pkg;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 4;
  localparam int NUM_TMR    = 2;
  localparam int TMR_STRIDE = 4;

  typedef enum logic [ADDR_W-1:0] {
    RA_T1_CNT_LO = 4'd0,
    RA_T1_CNT_HI = 4'd1,
    RA_T1_LAT_LO = 4'd2,
    RA_T1_LAT_HI = 4'd3,
    RA_T2_CNT_LO = 4'd4,
    RA_T2_CNT_HI = 4'd5,
    RA_T2_LAT_LO = 4'd6,
    RA_T2_LAT_HI = 4'd7,
    RA_CTRL      = 4'd8,
    RA_FLAG      = 4'd9,
    RA_ENABLE    = 4'd10
  } reg_addr_e;

  localparam int BIT_ANY       = 7;
  localparam int BIT_T1        = 6;
  localparam int BIT_T2        = 5;
  localparam int CTRL_T1_CONT  = 6;
  localparam int CTRL_T2_BLOCK = 5;

  function automatic int flag_bit(input int idx);
    return (idx == 0) ? BIT_T1 : BIT_T2;
  endfunction
endpackage

// File: rtl/dit_timer.sv
module dit_timer #(
  parameter int DATA_W       = 8,
  parameter bit CONT_CAPABLE = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lo_wr,
  input  logic                  hi_wr,
  input  logic [DATA_W-1:0]     wdata,
  input  logic                  cont_mode,
  input  logic                  flag_block,
  output logic [2*DATA_W-1:0]   count,
  output logic [2*DATA_W-1:0]   latch,
  output logic                  expire_set
);
  localparam int CNT_W = 2 * DATA_W;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] lat_q, lat_n;
  logic             lat_en;
  logic             fired_q, fired_n;
  logic             reload_q, reload_n;
  logic             at_zero;
  logic             cont_eff;

  assign cont_eff = CONT_CAPABLE & cont_mode;
  assign at_zero  = (cnt_q == '0);
  assign lat_en   = lo_wr | hi_wr;

  always_comb begin
    lat_n      = lat_q;
    cnt_n      = cnt_q;
    fired_n    = fired_q;
    reload_n   = reload_q;
    expire_set = 1'b0;
    if (lo_wr) begin
      lat_n[DATA_W-1:0] = wdata;
    end
    if (hi_wr) begin
      lat_n[CNT_W-1:DATA_W] = wdata;
      cnt_n    = {wdata, lat_q[DATA_W-1:0]};
      fired_n  = 1'b0;
      reload_n = 1'b0;
    end else if (reload_q) begin
      cnt_n    = lat_q;
      reload_n = 1'b0;
    end else begin
      cnt_n = cnt_q - ONE;
      if (at_zero) begin
        fired_n    = 1'b1;
        reload_n   = cont_eff;
        expire_set = !flag_block && (cont_eff || !fired_q);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      lat_q    <= '0;
      fired_q  <= 1'b1;
      reload_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_n;
      fired_q  <= fired_n;
      reload_q <= reload_n;
      if (lat_en) begin
        lat_q <= lat_n;
      end
    end
  end

  assign count = cnt_q;
  assign latch = lat_q;
endmodule

// File: rtl/dit_irq.sv
module dit_irq #(
  parameter int NUM_SRC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_req,
  input  logic [NUM_SRC-1:0] clr_req,
  input  logic               en_wr,
  input  logic [NUM_SRC-1:0] en_wdata,
  output logic [NUM_SRC-1:0] flags,
  output logic [NUM_SRC-1:0] enables,
  output logic               irq
);
  logic [NUM_SRC-1:0] flag_q, flag_n;
  logic [NUM_SRC-1:0] en_q;
  logic               flag_en;

  always_comb begin
    flag_n  = (flag_q & ~clr_req) | set_req;
    flag_en = |(set_req | clr_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      if (flag_en) begin
        flag_q <= flag_n;
      end
      if (en_wr) begin
        en_q <= en_wdata;
      end
    end
  end

  assign flags   = flag_q;
  assign enables = en_q;
  assign irq     = |(flag_q & en_q);
endmodule

// File: rtl/dit_top.sv
module dit_top #(
  parameter int DATA_W = dit_pkg::DATA_W,
  parameter int ADDR_W = dit_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  import dit_pkg::*;

  localparam int CNT_W = 2 * DATA_W;
  localparam int NT    = NUM_TMR;

  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic [NT-1:0]    lo_wr, hi_wr, lo_rd, set_req, clr_req, cont_mode, flag_block;
  logic [NT-1:0]    flags, enables, en_wdata;
  logic [CNT_W-1:0] cnt_arr [NT];
  logic [CNT_W-1:0] lat_arr [NT];
  logic [DATA_W-1:0] ctrl_q;
  logic             ctrl_en, flag_wr, en_wr;
  logic [DATA_W-1:0] flag_byte, en_byte;
  logic [CNT_W-1:0] t1_cnt, t1_lat, t2_cnt;
  logic             t2_block;

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  assign ctrl_en = wr_en && (addr == RA_CTRL);
  assign flag_wr = wr_en && (addr == RA_FLAG);
  assign en_wr   = wr_en && (addr == RA_ENABLE);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_q <= '0;
    end else if (ctrl_en) begin
      ctrl_q <= wr_data;
    end
  end

  assign cont_mode  = {1'b0, ctrl_q[CTRL_T1_CONT]};
  assign flag_block = {ctrl_q[CTRL_T2_BLOCK], 1'b0};

  genvar gi;
  generate
    for (gi = 0; gi < NT; gi++) begin : g_tmr
      localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(gi * TMR_STRIDE);
      localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(gi * TMR_STRIDE + 1);
      localparam int FB = flag_bit(gi);

      assign lo_wr[gi]    = wr_en && (addr == LO_A);
      assign hi_wr[gi]    = wr_en && (addr == HI_A);
      assign lo_rd[gi]    = rd_en && (addr == LO_A);
      assign clr_req[gi]  = (flag_wr && wr_data[FB]) || lo_rd[gi] || hi_wr[gi];
      assign en_wdata[gi] = wr_data[FB];

      dit_timer #(
        .DATA_W      (DATA_W),
        .CONT_CAPABLE(gi == 0)
      ) u_tmr (
        .clk       (clk),
        .rst_n     (rst_sync_n),
        .lo_wr     (lo_wr[gi]),
        .hi_wr     (hi_wr[gi]),
        .wdata     (wr_data),
        .cont_mode (cont_mode[gi]),
        .flag_block(flag_block[gi]),
        .count     (cnt_arr[gi]),
        .latch     (lat_arr[gi]),
        .expire_set(set_req[gi])
      );
    end
  endgenerate

  dit_irq #(.NUM_SRC(NT)) u_irq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_req (set_req),
    .clr_req (clr_req),
    .en_wr   (en_wr),
    .en_wdata(en_wdata),
    .flags   (flags),
    .enables (enables),
    .irq     (irq)
  );

  always_comb begin
    flag_byte          = '0;
    en_byte            = '0;
    flag_byte[BIT_ANY] = irq;
    for (int i = 0; i < NT; i++) begin
      flag_byte[flag_bit(i)] = flags[i];
      en_byte[flag_bit(i)]   = enables[i];
    end
  end

  always_comb begin
    case (addr)
      RA_T1_CNT_LO: rd_data = cnt_arr[0][DATA_W-1:0];
      RA_T1_CNT_HI: rd_data = cnt_arr[0][CNT_W-1:DATA_W];
      RA_T1_LAT_LO: rd_data = lat_arr[0][DATA_W-1:0];
      RA_T1_LAT_HI: rd_data = lat_arr[0][CNT_W-1:DATA_W];
      RA_T2_CNT_LO: rd_data = cnt_arr[1][DATA_W-1:0];
      RA_T2_CNT_HI: rd_data = cnt_arr[1][CNT_W-1:DATA_W];
      RA_T2_LAT_LO: rd_data = lat_arr[1][DATA_W-1:0];
      RA_T2_LAT_HI: rd_data = lat_arr[1][CNT_W-1:DATA_W];
      RA_CTRL:      rd_data = ctrl_q;
      RA_FLAG:      rd_data = flag_byte;
      RA_ENABLE:    rd_data = en_byte;
      default:      rd_data = '0;
    endcase
  end

  assign t1_cnt   = cnt_arr[0];
  assign t1_lat   = lat_arr[0];
  assign t2_cnt   = cnt_arr[1];
  assign t2_block = flag_block[1];
endmodule

// File: rtl/dit_chk.sv
module dit_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   addr,
  input logic                wr_en,
  input logic [DATA_W-1:0]   wr_data,
  input logic [DATA_W-1:0]   rd_data,
  input logic                irq,
  input logic [2*DATA_W-1:0] t1_cnt,
  input logic [2*DATA_W-1:0] t1_lat,
  input logic [1:0]          flags,
  input logic                t2_block
);
  import dit_pkg::*;
  localparam int CNT_W = 2 * DATA_W;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // R2
  t1_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == RA_T1_CNT_HI) |=>
      (t1_cnt == {$past(wr_data), $past(t1_lat[DATA_W-1:0])}));

  // R3
  t1_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && addr == RA_T1_CNT_HI) && t1_cnt != '0 && t1_cnt != '1) |=>
      (t1_cnt == $past(t1_cnt) - ONE));

  // R4
  t1_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> ($past(t1_cnt) == '0));

  // R6
  t2_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[1]) |-> !$past(t2_block));

  // R7
  t2_hi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == RA_T2_CNT_HI) |=> !flags[1]);

  // R8
  flag_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == RA_FLAG) |-> (rd_data[BIT_ANY] == irq));
endmodule

bind dit_top dit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .addr    (addr),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .irq     (irq),
  .t1_cnt  (t1_cnt),
  .t1_lat  (t1_lat),
  .flags   (flags),
  .t2_block(t2_block)
);

// File: tb/tb_dit_top.sv
`timescale 1ns/1ps
module tb_dit_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] addr;
  logic       wr_en, rd_en;
  logic [7:0] wr_data, rd_data;
  logic       irq;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [3:0] A_T1LO = 4'd0, A_T1HI = 4'd1, A_T1LL = 4'd2;
  localparam logic [3:0] A_T2LO = 4'd4, A_T2HI = 4'd5;
  localparam logic [3:0] A_CTRL = 4'd8, A_FLAG = 4'd9, A_EN = 4'd10;

  int t1_list [7] = '{0, 1, 2, 3, 7, 100, 300};
  int cont_list [3] = '{0, 4, 9};
  int t2_list [2] = '{2, 50};

  always #2.5 clk = ~clk;

  dit_top dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_clr(input logic [3:0] a);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd8(input logic [3:0] a, output logic [7:0] v);
    addr = a;
    #0.5 v = rd_data;
  endtask

  task automatic rd16(input logic [3:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd8(a, lo);
    rd8(a + 4'd1, hi);
    v = {hi, lo};
  endtask

  task automatic load(input logic [3:0] lo_a, input int n);
    wr(lo_a, n[7:0]);
    wr(lo_a + 4'd1, n[15:8]);
  endtask

  task automatic wait_irq(input int maxc, output int n);
    n = 0;
    while (!irq && n < maxc) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic count_irq(input int cyc, output int hits);
    hits = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (irq) hits++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] w;
    int n, hits;
    rst_n = 1'b0; addr = '0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state and quiet until loaded
    chk("R1 irq", irq, 0);
    rd8(A_CTRL, b); chk("R1 ctrl", b, 0);
    rd8(A_EN, b);   chk("R1 enable", b, 0);
    rd16(A_T1LL, w); chk("R1 t1 latch", w, 0);
    repeat (20) @(negedge clk);
    rd8(A_FLAG, b); chk("R1 no flag before load", b, 0);

    wr(A_EN, 8'h60);
    rd8(A_EN, b); chk("R8 enable readback", b, 8'h60);

    // R4 one-shot timing sweep on timer 1
    foreach (t1_list[i]) begin
      load(A_T1LO, t1_list[i]);
      wait_irq(t1_list[i] + 10, n);
      chk("R4 t1 delay", n, t1_list[i] + 1);
      rd8(A_FLAG, b); chk("R8 flag byte t1", b, 8'hC0);
      wr(A_FLAG, 8'h40);
      chk("R7 w1c t1", irq, 0);
    end

    // R3 countdown readback, R2 latch behaviour
    load(A_T1LO, 1000);
    rd16(A_T1LO, w); chk("R3 count at load", w, 1000);
    repeat (10) @(negedge clk);
    rd16(A_T1LO, w); chk("R3 count after 10", w, 990);
    rd16(A_T1LL, w); chk("R2 latch", w, 1000);
    wr(A_T1LO, 8'h11);
    rd16(A_T1LO, w); chk("R2 low write leaves counter", w, 989);
    rd16(A_T1LL, w); chk("R2 low write latch", w, 16'h0311);

    // R4 once per load, R3 wrap
    load(A_T1LO, 20);
    wait_irq(40, n);
    chk("R4 t1 delay 20", n, 21);
    rd16(A_T1LO, w); chk("R3 wrap", w, 16'hFFFF);
    wr(A_FLAG, 8'h40);
    count_irq(66000, hits);
    chk("R4 no second flag after wrap", hits, 0);

    // R7 high write clears timer 1 flag
    load(A_T1LO, 5);
    wait_irq(20, n);
    chk("R7 t1 flag set", irq, 1);
    wr(A_T1HI, 8'h40);
    chk("R7 hi write clears t1", irq, 0);

    // R7 read clear only on low byte
    load(A_T1LO, 3);
    wait_irq(20, n);
    rd_clr(A_T1HI);
    chk("R7 hi read keeps flag", irq, 1);
    rd_clr(A_T1LO);
    chk("R7 lo read clears", irq, 0);
    rd8(A_FLAG, b); chk("R7 flags after read", b, 0);

    // R7 writing zeros or other bits does not clear
    load(A_T1LO, 3);
    wait_irq(20, n);
    wr(A_FLAG, 8'h00); chk("R7 write 0 no effect", irq, 1);
    wr(A_FLAG, 8'h20); chk("R7 other bit no effect", irq, 1);
    wr(A_FLAG, 8'h40); chk("R7 write 1 clears", irq, 0);

    // R8 enable gating and bit 7
    wr(A_EN, 8'h20);
    load(A_T1LO, 4);
    repeat (10) @(negedge clk);
    chk("R8 masked irq", irq, 0);
    rd8(A_FLAG, b); chk("R8 masked flag byte", b, 8'h40);
    wr(A_EN, 8'h40);
    chk("R8 unmasked irq", irq, 1);
    rd8(A_FLAG, b); chk("R8 any bit", b, 8'hC0);
    wr(A_FLAG, 8'h40);
    wr(A_EN, 8'h60);

    // R5 free-running period
    wr(A_CTRL, 8'h40);
    rd8(A_CTRL, b); chk("R5 ctrl readback", b, 8'h40);
    foreach (cont_list[i]) begin
      load(A_T1LO, cont_list[i]);
      wait_irq(cont_list[i] + 10, n);
      chk("R5 first expiry", n, cont_list[i] + 1);
      for (int k = 0; k < 3; k++) begin
        wr(A_FLAG, 8'h40);
        wait_irq(cont_list[i] + 10, n);
        chk("R5 period", n, cont_list[i] + 1);
      end
    end

    // R9 switch to one-shot right after an expiry
    wr(A_CTRL, 8'h00);
    wr(A_FLAG, 8'h40);
    count_irq(60, hits);
    chk("R9 no flag after mode switch", hits, 0);

    // R4 timer 2 one-shot, R7 timer 2 high write clears
    foreach (t2_list[i]) begin
      load(A_T2LO, t2_list[i]);
      wait_irq(t2_list[i] + 10, n);
      chk("R4 t2 delay", n, t2_list[i] + 1);
      rd8(A_FLAG, b); chk("R8 flag byte t2", b, 8'hA0);
      wr(A_T2HI, 8'h20);
      chk("R7 t2 hi write clears", irq, 0);
    end

    // R6 timer 2 block mode
    wr(A_CTRL, 8'h20);
    load(A_T2LO, 3);
    count_irq(30, hits);
    chk("R6 no t2 irq", hits, 0);
    rd8(A_FLAG, b); chk("R6 no t2 flag", b, 0);
    rd16(A_T2LO, w); chk("R6 t2 still counts", w, 16'hFFE5);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule